// File: doc/BRIEF.md
# Packet Command PIO Read Sequencer

This block is the device side of a packet-command read carried out by programmed I/O. A host drives a small task-file register window. It programs a byte-count limit, issues the packet command, and pushes a 12-byte command packet through the 16-bit data port. Afterwards it pulls the reply one word at a time through that same port. The sequencer decodes one packet type, the read-blocks request. It fetches each reply word from a storage port that returns one 16-bit word per request, and it cuts the reply into bursts whose size is bounded by the host's limit.

Each burst is announced through the byte-count registers and the status register. Every burst end raises the interrupt line, and so does the arrival of the packet. When the last word has been read, the status returns to ready-only.

The controller has seven named states. **IDLE** is ready and waiting for a command. **PKT** asks for the packet, with DRQ set. **DECODE** is busy, latches the request and raises the interrupt. **SIZE** is busy and computes the next burst. **FETCH** is busy and issues the storage request. **WAIT** is busy until the storage word arrives. **HOLD** has DRQ set while a word waits for the host.

The transitions are as follows:
- IDLE→PKT on an accepted command.
- PKT→DECODE once six words have arrived.
- DECODE→SIZE always.
- SIZE→IDLE when nothing remains, and SIZE→FETCH otherwise.
- FETCH→WAIT always.
- WAIT→HOLD on storage valid.
- HOLD→FETCH on a read that is not the last word of the burst.
- HOLD→SIZE on the last read of a burst when more data remains.
- HOLD→IDLE on the last read of the last burst.

Top module: `pkt_pio_seq`

## Requirements
- R1: After reset, the status register (offset 7) reads 0x40. Bit 7 is busy, bit 6 is ready, bit 5 is fault, bit 3 is data-request and bit 0 is error. The interrupt output is low, and the byte-count registers (offset 4 low byte, offset 5 high byte) read 0.
- R2: Writing 0xA0 to offset 7 while idle, with feature bit 0 (offset 1) clear, makes the status read 0x48. This asks for the packet.
- R3: The packet is six writes to offset 0, each word carrying byte 2i in its low half and byte 2i+1 in its high half. Byte 0 = 0x28 selects a read. Bytes 2..5 hold the start block number, most significant byte first. Bytes 7..8 hold the block count, most significant byte first. The reply is count×2048 bytes taken from storage word addresses block×1024 upward, in order.
- R4: The interrupt rises after the sixth packet word. A read of the status register clears it.
- R5: Each burst is min(limit with bit 0 cleared, bytes remaining) bytes, where a limit below 2 acts as 2. That size is readable at offsets 4/5 whenever the data request is set. While idle, offsets 4/5 read back what the host wrote.
- R6: Status reads 0xC0 while a word is being fetched and 0x48 while a word is available. Each read of offset 0 returns the next reply word.
- R7: The interrupt is high immediately after the host reads the last word of every burst.
- R8: After the last word of the reply, status reads 0x40.
- R9: A packet command written while feature bit 0 is set is not accepted. Status stays 0x40 and no interrupt is raised.
- R10: Command codes other than 0xA0 are ignored. Writes to offset 0 outside the packet phase have no effect on a later transfer.
- R11: A packet whose byte 0 is not 0x28, or whose block count is zero, ends with the interrupt and status 0x40, with no storage request.
- R12: Storage requests are single-cycle pulses, exactly one per reply word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tf_wr | input | 1 | Register write strobe |
| tf_rd | input | 1 | Register read strobe (side effects on data and status offsets) |
| tf_addr | input | 3 | Register offset |
| tf_wdata | input | 16 | Write data |
| tf_rdata | output | 16 | Read data for the addressed register |
| irq | output | 1 | Interrupt request, level |
| st_req | output | 1 | Storage word request, one cycle |
| st_addr | output | 42 | Storage word address |
| st_data | input | 16 | Storage word returned |
| st_valid | input | 1 | Storage word valid |

## Verification
The in-line assertions watch several properties on every cycle:
- Storage requests never last two cycles.
- Every burst size loaded is even, non-zero and within the latched limit.
- A word is only offered while burst words remain.
- The burst-ending read always raises the interrupt.
- A command with the DMA-select bit set leaves the sequencer idle.

Other behaviour only the bench's scenarios can show. This covers the byte order of the packet fields, the exact split of a reply into bursts for odd, tiny and very large limits, and the word content against storage addresses. It also covers interrupt clearing by a status read and the idle status after unusual packets.

// File: rtl/pkt_pio_pkg.sv
package pkt_pio_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_PKT, S_DECODE, S_SIZE, S_FETCH, S_WAIT, S_HOLD
    } seq_state_t;

    localparam logic [2:0] A_DATA    = 3'd0;
    localparam logic [2:0] A_FEAT    = 3'd1;
    localparam logic [2:0] A_BCLO    = 3'd4;
    localparam logic [2:0] A_BCHI    = 3'd5;
    localparam logic [2:0] A_CMDSTAT = 3'd7;

    localparam int ST_BSY  = 7;
    localparam int ST_DRDY = 6;
    localparam int ST_DRQ  = 3;

    localparam logic [7:0] OP_PACKET      = 8'hA0;
    localparam logic [7:0] OP_READ_BLOCKS = 8'h28;
endpackage

// File: rtl/pkt_capture.sv
module pkt_capture #(
    parameter int NWORDS = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        wr_en,
    input  logic [15:0] wdata,
    output logic        full,
    output logic [7:0]  opcode,
    output logic [31:0] lba,
    output logic [15:0] nblk
);
    localparam int CW = $clog2(NWORDS + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            opcode <= '0;
            lba    <= '0;
            nblk   <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (wr_en && cnt_q != CW'(NWORDS)) begin
            cnt_q <= cnt_q + 1'b1;
            // Each word: even byte in bits 7:0, odd byte in bits 15:8.
            case (cnt_q)
                CW'(0): opcode      <= wdata[7:0];
                CW'(1): lba[31:16]  <= {wdata[7:0], wdata[15:8]};
                CW'(2): lba[15:0]   <= {wdata[7:0], wdata[15:8]};
                CW'(3): nblk[15:8]  <= wdata[15:8];
                CW'(4): nblk[7:0]   <= wdata[7:0];
                default: ;
            endcase
        end
    end

    assign full = (cnt_q == CW'(NWORDS));
endmodule

// File: rtl/burst_sizer.sv
module burst_sizer #(
    parameter int REM_W = 26
) (
    input  logic [14:0]      lim_half,
    input  logic [REM_W-1:0] remain,
    output logic [REM_W-1:0] burst_w,
    output logic [15:0]      burst_bytes
);
    logic [REM_W-1:0] lim_eff;

    always_comb begin
        lim_eff     = (lim_half == '0) ? REM_W'(1) : REM_W'(lim_half);
        burst_w     = (remain < lim_eff) ? remain : lim_eff;
        burst_bytes = {burst_w[14:0], 1'b0};
    end
endmodule

// File: rtl/pkt_pio_seq.sv
module pkt_pio_seq
    import pkt_pio_pkg::*;
#(
    parameter int BLK_BYTES = 2048,
    parameter int LBA_W     = 32,
    parameter int CNT_W     = 16,
    parameter int PKT_WORDS = 6,
    localparam int BLK_WLOG = $clog2(BLK_BYTES / 2),
    localparam int REM_W    = CNT_W + BLK_WLOG,
    localparam int ADDR_W   = LBA_W + BLK_WLOG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tf_wr,
    input  logic              tf_rd,
    input  logic [2:0]        tf_addr,
    input  logic [15:0]       tf_wdata,
    output logic [15:0]       tf_rdata,
    output logic              irq,
    output logic              st_req,
    output logic [ADDR_W-1:0] st_addr,
    input  logic [15:0]       st_data,
    input  logic              st_valid
);
    seq_state_t        state_q, state_d;
    logic              feat_q, irq_q;
    logic [15:0]       bc_q, word_q;
    logic [14:0]       lim_q;
    logic [REM_W-1:0]  remain_q, left_q, burst_w;
    logic [15:0]       burst_bytes;
    logic [ADDR_W-1:0] addr_q;
    logic              cap_full;
    logic [7:0]        opcode;
    logic [31:0]       lba;
    logic [15:0]       nblk;
    logic [7:0]        stat;

    wire cmd_wr  = tf_wr && tf_addr == A_CMDSTAT;
    wire data_wr = tf_wr && tf_addr == A_DATA;
    wire data_rd = tf_rd && tf_addr == A_DATA;
    wire stat_rd = tf_rd && tf_addr == A_CMDSTAT;
    wire accept  = state_q == S_IDLE && cmd_wr && tf_wdata[7:0] == OP_PACKET && !feat_q;
    wire last_rd = state_q == S_HOLD && data_rd && left_q == REM_W'(1);

    pkt_capture #(.NWORDS(PKT_WORDS)) u_cap (
        .clk(clk), .rst_n(rst_n), .clear(accept),
        .wr_en(state_q == S_PKT && data_wr), .wdata(tf_wdata),
        .full(cap_full), .opcode(opcode), .lba(lba), .nblk(nblk)
    );

    burst_sizer #(.REM_W(REM_W)) u_size (
        .lim_half(lim_q), .remain(remain_q),
        .burst_w(burst_w), .burst_bytes(burst_bytes)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (accept) state_d = S_PKT;
            S_PKT:    if (cap_full) state_d = S_DECODE;
            S_DECODE: state_d = S_SIZE;
            S_SIZE:   state_d = (remain_q == '0) ? S_IDLE : S_FETCH;
            S_FETCH:  state_d = S_WAIT;
            S_WAIT:   if (st_valid) state_d = S_HOLD;
            S_HOLD:   if (data_rd) begin
                          if (left_q != REM_W'(1))  state_d = S_FETCH;
                          else if (remain_q == '0)  state_d = S_IDLE;
                          else                      state_d = S_SIZE;
                      end
            default:  state_d = S_IDLE;
        endcase
    end

    // Datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            feat_q   <= 1'b0;
            irq_q    <= 1'b0;
            bc_q     <= '0;
            lim_q    <= '0;
            word_q   <= '0;
            remain_q <= '0;
            left_q   <= '0;
            addr_q   <= '0;
        end else begin
            if (state_q == S_IDLE && tf_wr) begin
                if (tf_addr == A_FEAT) feat_q     <= tf_wdata[0];
                if (tf_addr == A_BCLO) bc_q[7:0]  <= tf_wdata[7:0];
                if (tf_addr == A_BCHI) bc_q[15:8] <= tf_wdata[7:0];
            end
            if (accept) lim_q <= bc_q[15:1];
            if (state_q == S_DECODE) begin
                remain_q <= (opcode == OP_READ_BLOCKS) ? (REM_W'(nblk) << BLK_WLOG) : '0;
                addr_q   <= ADDR_W'(lba) << BLK_WLOG;
            end
            if (state_q == S_SIZE && remain_q != '0) begin
                left_q   <= burst_w;
                remain_q <= remain_q - burst_w;
                bc_q     <= burst_bytes;
            end
            if (state_q == S_WAIT && st_valid) word_q <= st_data;
            if (state_q == S_HOLD && data_rd) begin
                left_q <= left_q - 1'b1;
                addr_q <= addr_q + 1'b1;
            end
            if (accept)                             irq_q <= 1'b0;
            else if (state_q == S_DECODE || last_rd) irq_q <= 1'b1;
            else if (stat_rd)                        irq_q <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        stat          = '0;
        stat[ST_DRDY] = 1'b1;
        unique case (state_q)
            S_IDLE:                            ;
            S_PKT, S_HOLD:                     stat[ST_DRQ] = 1'b1;
            S_DECODE, S_SIZE, S_FETCH, S_WAIT: stat[ST_BSY] = 1'b1;
            default:                           ;
        endcase
        unique case (tf_addr)
            A_DATA:    tf_rdata = (state_q == S_HOLD) ? word_q : 16'h0;
            A_BCLO:    tf_rdata = {8'h0, bc_q[7:0]};
            A_BCHI:    tf_rdata = {8'h0, bc_q[15:8]};
            A_CMDSTAT: tf_rdata = {8'h0, stat};
            default:   tf_rdata = 16'h0;
        endcase
    end

    assign irq     = irq_q;
    assign st_req  = state_q == S_FETCH;
    assign st_addr = addr_q;

    // Assertions
    p_req_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        st_req |=> !st_req);
    p_burst_even_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SIZE && remain_q != '0) |=> (bc_q[0] == 1'b0 && bc_q != 16'h0));
    p_burst_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SIZE && remain_q != '0 && lim_q != '0) |=> (bc_q <= {lim_q, 1'b0}));
    p_word_left_r6: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_HOLD |-> left_q != '0);
    p_irq_burst_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        last_rd |=> irq);
    p_dma_select_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && cmd_wr && feat_q) |=> state_q == S_IDLE);
endmodule

// File: tb/pkt_pio_seq_tb.sv
`timescale 1ns/1ps
module pkt_pio_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tf_wr = 1'b0, tf_rd = 1'b0;
    logic [2:0]  tf_addr = '0;
    logic [15:0] tf_wdata = '0;
    logic [15:0] tf_rdata;
    logic        irq, st_req, st_valid;
    logic [41:0] st_addr;
    logic [15:0] st_data;
    int          n_chk = 0, n_fail = 0, req_cnt = 0;

    always #2 clk = ~clk;

    pkt_pio_seq u_dut (
        .clk(clk), .rst_n(rst_n), .tf_wr(tf_wr), .tf_rd(tf_rd), .tf_addr(tf_addr),
        .tf_wdata(tf_wdata), .tf_rdata(tf_rdata), .irq(irq), .st_req(st_req),
        .st_addr(st_addr), .st_data(st_data), .st_valid(st_valid)
    );

    function automatic logic [15:0] pat(input logic [41:0] a);
        return a[15:0] ^ {a[31:24], a[39:32]} ^ 16'h5A3C;
    endfunction

    // Storage model: one-cycle latency
    always @(posedge clk) begin
        if (!rst_n) begin
            st_valid <= 1'b0;
            st_data  <= '0;
        end else begin
            st_valid <= st_req;
            if (st_req) begin
                st_data <= pat(st_addr);
                req_cnt <= req_cnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Tasks are entered at a negedge and return at a negedge.
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        tf_addr = a; tf_wdata = d; tf_wr = 1'b1;
        @(negedge clk);
        tf_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        tf_addr = a; tf_rd = 1'b1;
        #1 d = tf_rdata;
        @(negedge clk);
        tf_rd = 1'b0;
    endtask

    task automatic run_xfer(input logic [31:0] lba, input logic [15:0] nblk,
                            input logic [15:0] lim, input logic [7:0] op);
        logic [7:0]  b [12];
        logic [15:0] s, d, lo, hi;
        logic [41:0] wa;
        longint      rem, burst, lim_e, words;
        int          errs, reqs0;
        for (int i = 0; i < 12; i++) b[i] = 8'h0;
        b[0] = op; b[2] = lba[31:24]; b[3] = lba[23:16]; b[4] = lba[15:8]; b[5] = lba[7:0];
        b[7] = nblk[15:8]; b[8] = nblk[7:0];
        wr(3'd4, {8'h0, lim[7:0]});
        wr(3'd5, {8'h0, lim[15:8]});
        wr(3'd7, 16'h00A0);
        rd(3'd7, s);
        chk(s == 16'h0048, "R2 status after packet command", s, 16'h48);
        reqs0 = req_cnt;
        for (int i = 0; i < 6; i++) wr(3'd0, {b[2*i+1], b[2*i]});
        for (int k = 0; k < 20 && !irq; k++) @(negedge clk);
        chk(irq == 1'b1, "R4 irq after packet", irq, 1);
        rd(3'd7, s);
        chk(irq == 1'b0, "R4 irq cleared by status read", irq, 0);
        rem   = (op == 8'h28) ? longint'(nblk) * 2048 : 0;
        words = rem / 2;
        lim_e = longint'(lim) & ~longint'(1);
        if (lim_e < 2) lim_e = 2;
        wa    = {lba, 10'b0};
        errs  = 0;
        while (rem > 0) begin
            do rd(3'd7, s); while (s[7]);
            chk(s == 16'h0048, "R6 word available status", s, 16'h48);
            burst = (rem < lim_e) ? rem : lim_e;
            rd(3'd4, lo);
            rd(3'd5, hi);
            chk({hi[7:0], lo[7:0]} == burst[15:0], "R5 burst byte count", {hi[7:0], lo[7:0]}, burst);
            for (longint w = 0; w < burst / 2; w++) begin
                if (w > 0) begin
                    do rd(3'd7, s); while (!s[3]);
                end
                rd(3'd0, d);
                if (d != pat(wa)) errs++;
                wa = wa + 1'b1;
            end
            chk(irq == 1'b1, "R7 irq at burst end", irq, 1);
            rem = rem - burst;
        end
        do rd(3'd7, s); while (s[7]);
        chk(s == 16'h0040, "R8 final status", s, 16'h40);
        chk(errs == 0, "R3 reply word content", errs, 0);
        chk(longint'(req_cnt - reqs0) == words, "R12 storage requests per word", req_cnt - reqs0, words);
    endtask

    localparam logic [63:0] VEC [6] = '{
        {32'h0000_0000, 16'd1, 16'd5120},
        {32'h0000_0003, 16'd2, 16'd4095},
        {32'h0012_3456, 16'd2, 16'd1000},
        {32'h0000_0009, 16'd1, 16'd1},
        {32'hFFFF_FFFE, 16'd1, 16'hFFFF},
        {32'h0000_0001, 16'd3, 16'd5120}
    };

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [15:0] s, lo, hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd7, s);  chk(s == 16'h0040, "R1 reset status", s, 16'h40);
        chk(irq == 1'b0, "R1 reset irq", irq, 0);
        rd(3'd4, lo); rd(3'd5, hi);
        chk({hi[7:0], lo[7:0]} == 16'h0, "R1 reset byte count", {hi[7:0], lo[7:0]}, 0);

        for (int v = 0; v < 6; v++)
            run_xfer(VEC[v][63:32], VEC[v][31:16], VEC[v][15:0], 8'h28);

        // R5 limit readback while idle
        wr(3'd4, 16'h0034); wr(3'd5, 16'h0012);
        rd(3'd4, lo); rd(3'd5, hi);
        chk({hi[7:0], lo[7:0]} == 16'h1234, "R5 idle limit readback", {hi[7:0], lo[7:0]}, 16'h1234);

        // R9 DMA select blocks the packet command
        wr(3'd1, 16'h0001); wr(3'd7, 16'h00A0);
        repeat (4) @(negedge clk);
        rd(3'd7, s);  chk(s == 16'h0040, "R9 status with DMA select", s, 16'h40);
        chk(irq == 1'b0, "R9 no irq with DMA select", irq, 0);
        wr(3'd1, 16'h0000);

        // R10 other commands and stray data writes
        wr(3'd7, 16'h00EC);
        rd(3'd7, s);  chk(s == 16'h0040, "R10 unknown command ignored", s, 16'h40);
        wr(3'd0, 16'hBEEF); wr(3'd0, 16'h1234);
        rd(3'd7, s);  chk(s == 16'h0040, "R10 stray data write ignored", s, 16'h40);
        run_xfer(32'h5, 16'd1, 16'd2048, 8'h28);

        // R11 packets with nothing to send
        run_xfer(32'h7, 16'd4, 16'd512, 8'h12);
        run_xfer(32'h7, 16'd0, 16'd512, 8'h28);
        chk(irq == 1'b0, "R11 irq cleared at end", irq, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule